// File: doc/BRIEF.md
# Float-to-Unsigned Converter with Ties-Away Rounding

This block turns one IEEE-754 floating-point operand (half, single or double precision) into an unsigned integer of 32 or 64 bits. Rounding is always to the nearest integer, and a value exactly halfway between two integers goes to the one of larger magnitude. No global rounding-mode setting affects it. A narrow (32-bit) result is zero-extended onto the 64-bit output bus.

Out-of-range inputs do not wrap. Positive overflow, including positive infinity, saturates to the all-ones value of the chosen width. Negative inputs and NaNs return zero. Two exception flags, invalid and inexact, travel with each result. The surrounding logic decides whether to accumulate them or to trap on them.

The converter has one register stage. An operand offered with the input strobe gives its result, flags and output strobe on the following clock edge. The outputs then hold until the next accepted operand.

Top module: `flt_to_uint_rna`

## Requirements
- R1: A result, its flags and `out_valid` appear on the first rising edge after `in_valid` is sampled high. When `in_valid` is low, `out_valid` falls and the result and flags keep their values.
- R2: The format code selects the operand type. 2'b00 is single, with the operand in `in_bits[31:0]`. 2'b01 is double, using all 64 bits. 2'b11 is half, with the operand in `in_bits[15:0]`. Bits above the selected operand are ignored. Code 2'b10 gives result 0 with invalid set and inexact clear.
- R3: `wide_sel`=1 gives a 64-bit result. `wide_sel`=0 gives a 32-bit result, and `out_result[63:32]` is then zero.
- R4: In-range positive values round to nearest. A fraction of exactly one half rounds up in magnitude (2.5 becomes 3, 0.5 becomes 1). A fraction below one half truncates.
- R5: For an in-range positive non-special input, inexact is set exactly when the input is not an integer. Invalid stays clear.
- R6: A NaN of any sign gives result 0 with invalid set and inexact clear.
- R7: +infinity, or a positive value whose rounded result exceeds 2^W-1 (W being the selected width), gives all ones in the low W bits with invalid set and inexact clear. A value that rounds to exactly 2^W-1 does not saturate.
- R8: A negative input whose magnitude rounds to zero (for example -0.4) gives 0 with inexact set. A negative input whose magnitude rounds to a nonzero value (for example -0.5, -1.0 or -infinity) gives 0 with invalid set.
- R9: +0 and -0 give 0 with no flags. Any subnormal input gives 0 with inexact set and invalid clear.
- R10: Invalid and inexact are never both set on one result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_bits | input | 64 | Raw floating-point bits, right-aligned |
| fmt_code | input | 2 | Operand format: 00 single, 01 double, 11 half, 10 illegal |
| wide_sel | input | 1 | 1 selects a 64-bit result, 0 a 32-bit result |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 64 | Converted unsigned integer, zero-extended in narrow mode |
| out_invalid | output | 1 | Invalid-operation flag for this result |
| out_inexact | output | 1 | Inexact flag for this result |

## Verification
Each format is driven with exact halves (0.5, 1.5, 2.5, 3.5) and with values just below one half. These separate ties-away rounding from truncation and from ties-to-even. The largest representable values below 2^32 and 2^64 are paired with the first values that round past them. For example, 4294967294.5 must round to all ones without saturating, while 4294967295.5 must saturate. This places the overflow boundary after rounding rather than before it. Negative inputs on either side of the one-half point, zeros, subnormals, infinities, NaNs and the illegal format code fix which flag each class raises. Half and single operands carry garbage in the unused upper bits to show that those bits are ignored.

// File: rtl/f2u_pkg.sv
package f2u_pkg;
  localparam int RAW_W    = 64;
  localparam int INT_W    = 64;
  localparam int NARROW_W = 32;
  localparam int SIG_W    = 53;
  localparam int EXP_W    = 13;
  localparam int FIX_W    = SIG_W + INT_W;
  localparam int SH_W     = 7;
  localparam int NFMT     = 3;

  localparam logic [1:0] FMT_SINGLE = 2'b00;
  localparam logic [1:0] FMT_DOUBLE = 2'b01;
  localparam logic [1:0] FMT_ILLEGAL = 2'b10;
  localparam logic [1:0] FMT_HALF   = 2'b11;

  typedef enum logic [2:0] {
    CL_ZERO, CL_TINY, CL_NORM, CL_INF, CL_NAN
  } fclass_e;

  typedef struct packed {
    logic                    sign;
    fclass_e                 cls;
    logic signed [EXP_W-1:0] exp;
    logic [SIG_W-1:0]        sig;
  } unpk_t;

  typedef struct packed {
    logic [INT_W:0] mag;
    logic           lost;
    logic           huge;
  } rnd_t;

  // index 0 half, 1 single, 2 double
  function automatic int fmt_ew(int idx);
    return (idx == 0) ? 5 : (idx == 1) ? 8 : 11;
  endfunction

  function automatic int fmt_mw(int idx);
    return (idx == 0) ? 10 : (idx == 1) ? 23 : 52;
  endfunction

  // Largest value of the chosen result width, one bit wider than the bus.
  function automatic logic [INT_W:0] width_limit(logic wide);
    logic [INT_W:0] lim;
    lim = '0;
    if (wide) lim[INT_W-1:0] = '1;
    else      lim[NARROW_W-1:0] = '1;
    return lim;
  endfunction

  // Magnitude of sig * 2^(e - (SIG_W-1)), rounded to nearest, ties away.
  // Fixed point with SIG_W fraction bits: the hidden bit lands at e+SIG_W.
  function automatic rnd_t round_ties_away(logic signed [EXP_W-1:0] e,
                                           logic [SIG_W-1:0] sig);
    rnd_t              r;
    logic [FIX_W-1:0]  fixed;
    logic [INT_W-1:0]  ipart;
    logic              half;
    logic              sticky;
    logic [SH_W-1:0]   sh;
    r = '0;
    if (e < -EXP_W'(1)) begin
      r.lost = |sig;
    end else if (e > EXP_W'(INT_W - 1)) begin
      r.huge = 1'b1;
    end else begin
      sh     = SH_W'(e + EXP_W'(1));
      fixed  = FIX_W'(sig) << sh;
      ipart  = fixed[FIX_W-1:SIG_W];
      half   = fixed[SIG_W-1];
      sticky = |fixed[SIG_W-2:0];
      r.mag  = {1'b0, ipart} + (INT_W+1)'(half);
      r.lost = half | sticky;
    end
    return r;
  endfunction
endpackage

// File: rtl/f2u_field_split.sv
module f2u_field_split
  import f2u_pkg::*;
#(
  parameter int EW = 8,
  parameter int MW = 23
) (
  input  logic [EW+MW:0] fp,
  output unpk_t          fields
);
  localparam int TOPB = EW + MW;
  localparam int BIAS = (1 << (EW - 1)) - 1;

  logic [EW-1:0] e_f;
  logic [MW-1:0] m_f;

  assign e_f = fp[TOPB-1:MW];
  assign m_f = fp[MW-1:0];

  always_comb begin
    fields.sign = fp[TOPB];
    fields.exp  = EXP_W'(e_f) - EXP_W'(BIAS);
    fields.sig  = SIG_W'({1'b1, m_f}) << (SIG_W - 1 - MW);
    if (&e_f)        fields.cls = (|m_f) ? CL_NAN : CL_INF;
    else if (e_f == '0) fields.cls = (|m_f) ? CL_TINY : CL_ZERO;
    else             fields.cls = CL_NORM;
  end
endmodule

// File: rtl/f2u_unpack.sv
module f2u_unpack
  import f2u_pkg::*;
(
  input  logic [RAW_W-1:0] raw,
  input  logic [1:0]       fmt_code,
  output unpk_t            opnd,
  output logic             fmt_bad
);
  unpk_t cand [NFMT];

  for (genvar g = 0; g < NFMT; g++) begin : g_fmt
    localparam int EWG = fmt_ew(g);
    localparam int MWG = fmt_mw(g);
    f2u_field_split #(.EW(EWG), .MW(MWG)) u_split (
      .fp     (raw[EWG+MWG:0]),
      .fields (cand[g])
    );
  end

  always_comb begin
    fmt_bad = 1'b0;
    case (fmt_code)
      FMT_HALF:   opnd = cand[0];
      FMT_SINGLE: opnd = cand[1];
      FMT_DOUBLE: opnd = cand[2];
      default: begin
        opnd    = cand[1];
        fmt_bad = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/f2u_round.sv
module f2u_round
  import f2u_pkg::*;
(
  input  logic signed [EXP_W-1:0] exp_in,
  input  logic [SIG_W-1:0]        sig_in,
  output rnd_t                    rnd
);
  assign rnd = round_ties_away(exp_in, sig_in);
endmodule

// File: rtl/f2u_resolve.sv
module f2u_resolve
  import f2u_pkg::*;
(
  input  unpk_t            opnd,
  input  rnd_t             rnd,
  input  logic             fmt_bad,
  input  logic             wide,
  output logic [INT_W-1:0] res,
  output logic             inv,
  output logic             inx,
  output logic             ev_nan,
  output logic             ev_neg,
  output logic             ev_sat
);
  logic [INT_W:0] lim;
  logic           over;

  assign lim    = width_limit(wide);
  assign over   = rnd.huge || (rnd.mag > lim);
  assign ev_nan = !fmt_bad && (opnd.cls == CL_NAN);
  assign ev_neg = !fmt_bad && opnd.sign && (opnd.cls != CL_NAN);

  always_comb begin
    res    = '0;
    inv    = 1'b0;
    inx    = 1'b0;
    ev_sat = 1'b0;
    if (fmt_bad) begin
      inv = 1'b1;
    end else begin
      case (opnd.cls)
        CL_NAN:  inv = 1'b1;
        CL_ZERO: ;
        CL_TINY: inx = 1'b1;
        CL_INF: begin
          inv = 1'b1;
          if (!opnd.sign) begin
            res    = lim[INT_W-1:0];
            ev_sat = 1'b1;
          end
        end
        default: begin
          if (opnd.sign) begin
            if (!rnd.huge && rnd.mag == '0) inx = rnd.lost;
            else                            inv = 1'b1;
          end else if (over) begin
            res    = lim[INT_W-1:0];
            inv    = 1'b1;
            ev_sat = 1'b1;
          end else begin
            res = rnd.mag[INT_W-1:0];
            inx = rnd.lost;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/flt_to_uint_rna.sv
module flt_to_uint_rna
  import f2u_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [RAW_W-1:0] in_bits,
  input  logic [1:0]       fmt_code,
  input  logic             wide_sel,
  output logic             out_valid,
  output logic [INT_W-1:0] out_result,
  output logic             out_invalid,
  output logic             out_inexact
);
  unpk_t            w_opnd;
  rnd_t             w_rnd;
  logic             w_fmt_bad;
  logic [INT_W-1:0] w_res;
  logic             w_inv;
  logic             w_inx;
  logic             w_ev_nan;
  logic             w_ev_neg;
  logic             w_ev_sat;

  f2u_unpack u_unpack (
    .raw      (in_bits),
    .fmt_code (fmt_code),
    .opnd     (w_opnd),
    .fmt_bad  (w_fmt_bad)
  );

  f2u_round u_round (
    .exp_in (w_opnd.exp),
    .sig_in (w_opnd.sig),
    .rnd    (w_rnd)
  );

  f2u_resolve u_resolve (
    .opnd    (w_opnd),
    .rnd     (w_rnd),
    .fmt_bad (w_fmt_bad),
    .wide    (wide_sel),
    .res     (w_res),
    .inv     (w_inv),
    .inx     (w_inx),
    .ev_nan  (w_ev_nan),
    .ev_neg  (w_ev_neg),
    .ev_sat  (w_ev_sat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= w_res;
        out_invalid <= w_inv;
        out_inexact <= w_inx;
      end
    end
  end
endmodule

// File: rtl/flt_to_uint_rna_chk.sv
module flt_to_uint_rna_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        wide_sel,
  input logic        fmt_bad,
  input logic        ev_nan,
  input logic        ev_neg,
  input logic        ev_sat,
  input logic        out_valid,
  input logic [63:0] out_result,
  input logic        out_invalid,
  input logic        out_inexact
);
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_invalid)));

  p_bad_fmt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt_bad) |=> (out_result == 64'd0 && out_invalid && !out_inexact));

  p_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide_sel) |=> (out_result[63:32] == 32'd0));

  p_nan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_nan) |=> (out_result == 64'd0 && out_invalid && !out_inexact));

  p_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_sat) |=> (out_invalid && !out_inexact &&
      (out_result == 64'hFFFF_FFFF_FFFF_FFFF || out_result == 64'h0000_0000_FFFF_FFFF)));

  p_neg_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_neg) |=> (out_result == 64'd0));

  p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_inexact));
endmodule

bind flt_to_uint_rna flt_to_uint_rna_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .wide_sel    (wide_sel),
  .fmt_bad     (w_fmt_bad),
  .ev_nan      (w_ev_nan),
  .ev_neg      (w_ev_neg),
  .ev_sat      (w_ev_sat),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_invalid (out_invalid),
  .out_inexact (out_inexact)
);

// File: tb/flt_to_uint_rna_bench.sv
module flt_to_uint_rna_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_bits = '0;
  logic [1:0]  fmt_code = 2'b00;
  logic        wide_sel = 1'b0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_invalid;
  logic        out_inexact;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [63:0] q_res [$];
  logic [1:0]  q_flg [$];
  string       q_tag [$];

  localparam logic [63:0] ONES64 = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] ONES32 = 64'h0000_0000_FFFF_FFFF;
  localparam logic [63:0] JUNK   = 64'hA5A5_5A5A_0000_0000;

  always #10 clk = ~clk;

  flt_to_uint_rna u_flt_to_uint_rna (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .fmt_code(fmt_code), .wide_sel(wide_sel), .out_valid(out_valid),
    .out_result(out_result), .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  task automatic send(input logic [1:0] f, input logic w, input logic [63:0] b,
                      input logic [63:0] er, input logic einv, input logic einx,
                      input string tag);
    fmt_code = f;
    wide_sel = w;
    in_bits  = b;
    in_valid = 1'b1;
    q_res.push_back(er);
    q_flg.push_back({einv, einx});
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    in_bits  = '1;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (q_res.size() == 0) begin
        failures++;
        $display("FAIL R1 unexpected out_valid result=%h", out_result);
      end else begin
        logic [63:0] er;
        logic [1:0]  ef;
        string       tg;
        er = q_res.pop_front();
        ef = q_flg.pop_front();
        tg = q_tag.pop_front();
        if (out_result !== er || {out_invalid, out_inexact} !== ef) begin
          failures++;
          $display("FAIL %s result=%h exp=%h inv/inx=%b%b exp=%b%b",
                   tg, out_result, er, out_invalid, out_inexact, ef[1], ef[0]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_result !== 64'd0 || out_invalid !== 1'b0 || out_inexact !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset state valid=%b result=%h exp=0", out_valid, out_result);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R4 / R5 single
    send(2'b00, 1'b0, JUNK | 64'h4020_0000, 64'd3, 1'b0, 1'b1, "R4 single 2.5");
    send(2'b00, 1'b0, 64'h4019_999A, 64'd2, 1'b0, 1'b1, "R4 single 2.4");
    send(2'b00, 1'b1, 64'h4060_0000, 64'd4, 1'b0, 1'b1, "R4 single 3.5");
    send(2'b00, 1'b0, 64'h3F00_0000, 64'd1, 1'b0, 1'b1, "R4 single 0.5");
    send(2'b00, 1'b0, 64'h3E80_0000, 64'd0, 1'b0, 1'b1, "R4 single 0.25");
    send(2'b00, 1'b0, 64'h3F80_0000, 64'd1, 1'b0, 1'b0, "R5 single 1.0 exact");
    send(2'b00, 1'b0, 64'h4F7F_FFFF, 64'hFFFF_FF00, 1'b0, 1'b0, "R5 single max below 2^32");
    // R1 hold after idle
    idle(3);
    checks++;
    if (out_valid !== 1'b0 || out_result !== 64'hFFFF_FF00 || out_invalid !== 1'b0) begin
      failures++;
      $display("FAIL R1 hold result=%h exp=%h valid=%b", out_result, 64'hFFFF_FF00, out_valid);
    end

    // R3 widths
    send(2'b00, 1'b0, 64'h4F80_0000, ONES32, 1'b1, 1'b0, "R7 single 2^32 narrow");
    send(2'b00, 1'b1, 64'h4F80_0000, 64'h1_0000_0000, 1'b0, 1'b0, "R3 single 2^32 wide");
    send(2'b00, 1'b1, 64'h5F7F_FFFF, 64'hFFFF_FF00_0000_0000, 1'b0, 1'b0, "R3 single max below 2^64");
    send(2'b00, 1'b1, 64'h5F80_0000, ONES64, 1'b1, 1'b0, "R7 single 2^64 wide");
    send(2'b00, 1'b0, 64'h7F80_0000, ONES32, 1'b1, 1'b0, "R7 +inf narrow");
    send(2'b00, 1'b1, 64'h7F80_0000, ONES64, 1'b1, 1'b0, "R7 +inf wide");

    // R6 NaN, R8 negatives, R9 zero/subnormal
    send(2'b00, 1'b1, 64'h7FC0_0000, 64'd0, 1'b1, 1'b0, "R6 single qnan");
    send(2'b00, 1'b0, 64'hFF80_0001, 64'd0, 1'b1, 1'b0, "R6 single neg snan");
    send(2'b00, 1'b0, 64'hBECC_CCCD, 64'd0, 1'b0, 1'b1, "R8 single -0.4");
    send(2'b00, 1'b0, 64'hBF00_0000, 64'd0, 1'b1, 1'b0, "R8 single -0.5");
    send(2'b00, 1'b1, 64'hBF80_0000, 64'd0, 1'b1, 1'b0, "R8 single -1.0");
    send(2'b00, 1'b0, 64'hFF80_0000, 64'd0, 1'b1, 1'b0, "R8 -inf");
    send(2'b00, 1'b0, 64'h0000_0000, 64'd0, 1'b0, 1'b0, "R9 +0");
    send(2'b00, 1'b1, 64'h8000_0000, 64'd0, 1'b0, 1'b0, "R9 -0");
    send(2'b00, 1'b0, 64'h0000_0001, 64'd0, 1'b0, 1'b1, "R9 single subnormal");
    send(2'b00, 1'b0, 64'h8000_0001, 64'd0, 1'b0, 1'b1, "R9 neg subnormal");
    idle(1);

    // double
    send(2'b01, 1'b0, 64'h4004_0000_0000_0000, 64'd3, 1'b0, 1'b1, "R4 double 2.5");
    send(2'b01, 1'b0, 64'h3FF8_0000_0000_0000, 64'd2, 1'b0, 1'b1, "R4 double 1.5");
    send(2'b01, 1'b0, 64'h3FDF_FFFF_FFFF_FFFF, 64'd0, 1'b0, 1'b1, "R4 double just below half");
    send(2'b01, 1'b0, 64'h41EF_FFFF_FFD0_0000, ONES32, 1'b0, 1'b1, "R7 double 2^32-1.5 rounds to max no sat");
    send(2'b01, 1'b0, 64'h41EF_FFFF_FFF0_0000, ONES32, 1'b1, 1'b0, "R7 double 2^32-0.5 saturates");
    send(2'b01, 1'b1, 64'h41EF_FFFF_FFF0_0000, 64'h1_0000_0000, 1'b0, 1'b1, "R3 double 2^32-0.5 wide");
    send(2'b01, 1'b1, 64'h43EF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_F800, 1'b0, 1'b0, "R5 double max below 2^64");
    send(2'b01, 1'b1, 64'h43F0_0000_0000_0000, ONES64, 1'b1, 1'b0, "R7 double 2^64");
    send(2'b01, 1'b0, 64'h0000_0000_0000_0001, 64'd0, 1'b0, 1'b1, "R9 double subnormal");
    send(2'b01, 1'b0, 64'hC004_0000_0000_0000, 64'd0, 1'b1, 1'b0, "R8 double -2.5");
    send(2'b01, 1'b1, 64'h7FF8_0000_0000_0000, 64'd0, 1'b1, 1'b0, "R6 double nan");
    idle(2);

    // half, with junk in unused upper bits (R2)
    send(2'b11, 1'b0, JUNK | 64'h4100, 64'd3, 1'b0, 1'b1, "R2 half 2.5 upper ignored");
    send(2'b11, 1'b0, JUNK | 64'h3800, 64'd1, 1'b0, 1'b1, "R4 half 0.5");
    send(2'b11, 1'b1, 64'h7BFF, 64'd65504, 1'b0, 1'b0, "R5 half max");
    send(2'b11, 1'b0, 64'h7C00, ONES32, 1'b1, 1'b0, "R7 half +inf");
    send(2'b11, 1'b0, 64'h7E00, 64'd0, 1'b1, 1'b0, "R6 half nan");
    send(2'b11, 1'b0, 64'h0001, 64'd0, 1'b0, 1'b1, "R9 half subnormal");
    send(2'b11, 1'b0, 64'hB400, 64'd0, 1'b0, 1'b1, "R8 half -0.25");
    send(2'b10, 1'b0, 64'h3F80_0000, 64'd0, 1'b1, 1'b0, "R2 illegal format");
    send(2'b10, 1'b1, 64'h0000_0000, 64'd0, 1'b1, 1'b0, "R2 illegal format zero operand");
    idle(3);

    checks++;
    if (q_res.size() != 0) begin
      failures++;
      $display("FAIL R1 missing results pending=%0d exp=0", q_res.size());
    end
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 valid after idle=%b exp=0", out_valid);
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule